// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block drives a clock-output pin with a slow copy of one of five on-chip clocks. A source multiplexer picks the input clock, and a global gate decides whether any clock reaches the divider at all. A sixteen-stage binary toggle chain then divides the chosen clock by powers of two. One stage is routed to the output, so the output runs at Fin / 2^(N+1).

A six-bit control word holds three fields: the stage select N, a run enable and a divider bypass. Start and stop are clean. Setting the enable starts the chain from a cleared state, so the first high phase has its full length. Clearing the enable lets the current high phase finish. The chain then halts with the output parked low.

Both the enable and the bypass cross into the selected clock's domain through a two-flop synchroniser. The bypass sends the undivided source clock straight to the pin.

Top module: `clko_divider`

## Requirements
- R1: With the enable set and the bypass clear, the output runs at Fin / 2^(N+1) with a 50 % duty cycle. N is control bits [3:0]. Each high phase lasts exactly 2^N input-clock periods.
- R2: Setting the enable (control bit 4) from idle starts the chain from all-zero, so the first high phase is full length.
- R3: After the enable is cleared, a high phase already in progress completes at full length. The output then stays low and produces no further edges.
- R4: With the bypass (control bit 5) set, the output follows the selected source clock and has the same period.
- R5: The source select encodes the inputs as follows: 000 the fast crystal clock, 001 the slow crystal clock, 010 the system clock, 011 the fast RC clock and 101 the 48 MHz RC clock.
- R6: The reserved source codes 100, 110 and 111 feed a constant low to the divider, so the output makes no edges.
- R7: With the clock gate low, no clock reaches the divider and an idle output makes no edges.
- R8: Reset clears every stage, holds the output low and treats the enable as 0.
- R9: The enable and the bypass each pass two synchroniser flops in the selected clock's domain. The first output rise therefore comes no sooner than three source edges after the enable is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_xtal_hi | input | 1 | Fast crystal clock (code 000) |
| clk_xtal_lo | input | 1 | Slow crystal clock (code 001) |
| clk_sys | input | 1 | System bus clock (code 010) |
| clk_rc_hi | input | 1 | Fast RC clock (code 011) |
| clk_rc48 | input | 1 | 48 MHz RC clock (code 101) |
| src_sel | input | 3 | Source select code |
| gate_en | input | 1 | Global clock gate; 0 blocks every source |
| ctrl_word | input | 6 | [3:0] stage select N, [4] run enable, [5] divider bypass |
| clk_out | output | 1 | Divided or bypassed clock to the pin |

## Verification
The bench measures the high time for all sixteen stage selects and the full period for the low ones. An off-by-one stage tap or a skewed duty cycle would show as a wrong time. It drops the enable in the middle of a high phase. A design that cuts the output at once would emit a runt pulse, and one that fails to park would keep toggling. It also checks the bypass path, every legal source code, a reserved code, the closed gate and a reset taken mid-run. A broken mux, gate or reset would show up as edges that should not exist or as a wrong period. Finally it times the delay from the enable write to the first rise, which exposes a missing or shortened synchroniser.

// File: rtl/clko_pkg.sv
package clko_pkg;

    typedef enum logic [2:0] {
        SRC_XTAL_HI = 3'b000,
        SRC_XTAL_LO = 3'b001,
        SRC_SYS     = 3'b010,
        SRC_RC_HI   = 3'b011,
        SRC_RC48    = 3'b101
    } src_code_e;

    localparam int SYNC_DEPTH = 2;

endpackage

// File: rtl/clko_src_mux.sv
module clko_src_mux
    import clko_pkg::*;
(
    input  logic       clk_xtal_hi,
    input  logic       clk_xtal_lo,
    input  logic       clk_sys,
    input  logic       clk_rc_hi,
    input  logic       clk_rc48,
    input  logic [2:0] src_sel,
    input  logic       gate_en,
    output logic       clk_o
);
    logic picked;

    always_comb begin
        case (src_sel)
            SRC_XTAL_HI: picked = clk_xtal_hi;
            SRC_XTAL_LO: picked = clk_xtal_lo;
            SRC_SYS:     picked = clk_sys;
            SRC_RC_HI:   picked = clk_rc_hi;
            SRC_RC48:    picked = clk_rc48;
            default:     picked = 1'b0;   // reserved codes: constant low
        endcase
        clk_o = picked & gate_en;
    end
endmodule

// File: rtl/clko_sync.sv
module clko_sync #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/clko_div_chain.sv
module clko_div_chain #(
    parameter int STAGES = 16,
    localparam int SELW  = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SELW-1:0]   tap_sel,
    output logic              run_o,
    output logic [STAGES-1:0] cnt_o,
    output logic              div_o
);
    typedef struct packed {
        logic              run;
        logic [STAGES-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [STAGES:0] carry;
    logic            tap_bit;

    assign carry[0] = 1'b1;
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        // stage k toggles when every lower stage is high
        assign carry[k+1] = carry[k] & st_q.cnt[k];
    end

    assign tap_bit = st_q.cnt[tap_sel];

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            st_d.cnt = '0;
            if (en) st_d.run = 1'b1;
        end else if (en || tap_bit) begin
            st_d.cnt = st_q.cnt ^ carry[STAGES-1:0];
        end else begin
            // disabled and selected output low: park
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign cnt_o = st_q.cnt;
    assign div_o = tap_bit;
endmodule

// File: rtl/clko_divider.sv
module clko_divider
    import clko_pkg::*;
#(
    parameter int STAGES = 16,
    localparam int SELW  = $clog2(STAGES),
    localparam int EN_BIT  = SELW,
    localparam int BYP_BIT = SELW + 1,
    localparam int CTRLW   = SELW + 2
) (
    input  logic             rst_n,
    input  logic             clk_xtal_hi,
    input  logic             clk_xtal_lo,
    input  logic             clk_sys,
    input  logic             clk_rc_hi,
    input  logic             clk_rc48,
    input  logic [2:0]       src_sel,
    input  logic             gate_en,
    input  logic [CTRLW-1:0] ctrl_word,
    output logic             clk_out
);
    logic              clk_src;
    logic [1:0]        ctl_s;
    logic              en_s, byp_s;
    logic              run_q;
    logic [STAGES-1:0] cnt_q;
    logic              div_bit;

    clko_src_mux u_mux (
        .clk_xtal_hi (clk_xtal_hi),
        .clk_xtal_lo (clk_xtal_lo),
        .clk_sys     (clk_sys),
        .clk_rc_hi   (clk_rc_hi),
        .clk_rc48    (clk_rc48),
        .src_sel     (src_sel),
        .gate_en     (gate_en),
        .clk_o       (clk_src)
    );

    clko_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     ({ctrl_word[BYP_BIT], ctrl_word[EN_BIT]}),
        .q     (ctl_s)
    );

    assign en_s  = ctl_s[0];
    assign byp_s = ctl_s[1];

    clko_div_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .en      (en_s),
        .tap_sel (ctrl_word[SELW-1:0]),
        .run_o   (run_q),
        .cnt_o   (cnt_q),
        .div_o   (div_bit)
    );

    always_comb begin
        clk_out = byp_s ? clk_src : div_bit;
    end
endmodule

// File: rtl/clko_divider_chk.sv
module clko_divider_chk #(
    parameter int STAGES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_s,
    input logic              byp_s,
    input logic              run_q,
    input logic [STAGES-1:0] cnt_q,
    input logic              div_bit,
    input logic              clk_out
);
    AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !byp_s) |-> !clk_out); // R3

    AST_STOP_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> !$past(div_bit)); // R3

    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (cnt_q == '0)); // R2

    AST_EN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(en_s)); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R1
endmodule

bind clko_divider clko_divider_chk #(.STAGES(STAGES)) u_chk (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .en_s    (en_s),
    .byp_s   (byp_s),
    .run_q   (run_q),
    .cnt_q   (cnt_q),
    .div_bit (div_bit),
    .clk_out (clk_out)
);

// File: tb/clko_divider_tb.sv
`timescale 1ns/1ps
module clko_divider_tb;

    typedef struct packed {
        logic [3:0]  n;
        int unsigned half_ns;
    } vec_t;

    // R1: high time = 2^N fast-crystal periods of 4 ns
    localparam vec_t VEC [16] = '{
        '{4'd0, 4},      '{4'd1, 8},      '{4'd2, 16},     '{4'd3, 32},
        '{4'd4, 64},     '{4'd5, 128},    '{4'd6, 256},    '{4'd7, 512},
        '{4'd8, 1024},   '{4'd9, 2048},   '{4'd10, 4096},  '{4'd11, 8192},
        '{4'd12, 16384}, '{4'd13, 32768}, '{4'd14, 65536}, '{4'd15, 131072}
    };

    logic       clk = 1'b0;          // also the fast crystal clock
    logic       clk_xtal_lo = 1'b0;
    logic       clk_sys = 1'b0;
    logic       clk_rc_hi = 1'b0;
    logic       clk_rc48 = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel = 3'b000;
    logic       gate_en = 1'b1;
    logic [5:0] ctrl_word = '0;
    logic       clk_out;

    int tests = 0;
    int fails = 0;
    int edges = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always #5 clk_xtal_lo = ~clk_xtal_lo;
    always #3 clk_sys = ~clk_sys;
    always #4 clk_rc_hi = ~clk_rc_hi;
    always #6 clk_rc48 = ~clk_rc48;

    always @(posedge clk_out) edges++;

    clko_divider u_dut (
        .rst_n       (rst_n),
        .clk_xtal_hi (clk),
        .clk_xtal_lo (clk_xtal_lo),
        .clk_sys     (clk_sys),
        .clk_rc_hi   (clk_rc_hi),
        .clk_rc48    (clk_rc48),
        .src_sel     (src_sel),
        .gate_en     (gate_en),
        .ctrl_word   (ctrl_word),
        .clk_out     (clk_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic park();
        ctrl_word[4] = 1'b0;
        ctrl_word[5] = 1'b0;
        if (clk_out) @(negedge clk_out);
        wait_cyc(40);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(190000 * 4);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        time t0, t1, t2;
        int  e0;
        int  src_code [4] = '{1, 2, 3, 5};
        int  src_half [4] = '{5, 3, 4, 6};

        // R8: reset state
        ctrl_word = 6'b010000;
        wait_cyc(5);
        check("R8 out low in reset", clk_out, 0);
        ctrl_word = '0;
        rst_n = 1'b1;
        wait_cyc(5);
        check("R8 out low after reset", clk_out, 0);

        // R1/R2: table walk over every stage select
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ctrl_word = {2'b01, VEC[i].n};
            @(posedge clk_out); t0 = $time;
            @(negedge clk_out); t1 = $time;
            check($sformatf("R1 R2 high time N=%0d", VEC[i].n), t1 - t0, VEC[i].half_ns);
            if (VEC[i].n <= 4'd6) begin
                @(posedge clk_out); t2 = $time;
                check($sformatf("R1 period N=%0d", VEC[i].n), t2 - t0, 2 * VEC[i].half_ns);
            end
            park();
        end

        // R9: latency from enable write to first rise
        ctrl_word = 6'b010000;
        t0 = $time;
        @(posedge clk_out); t1 = $time;
        check("R9 enable latency at least 3 edges", ((t1 - t0) >= 10) ? 1 : 0, 1);
        park();

        // R3: drop enable mid high phase
        ctrl_word = 6'b010011;
        @(posedge clk_out); t0 = $time;
        wait_cyc(2);
        ctrl_word[4] = 1'b0;
        @(negedge clk_out); t1 = $time;
        check("R3 high phase completes", t1 - t0, 32);
        e0 = edges;
        wait_cyc(100);
        check("R3 no edges after stop", edges - e0, 0);
        check("R3 parked low", clk_out, 0);

        // R5: each other legal source with N=0
        for (int s = 0; s < 4; s++) begin
            src_sel = 3'(src_code[s]);
            wait_cyc(4);
            ctrl_word = 6'b010000;
            @(posedge clk_out); t0 = $time;
            @(posedge clk_out); t1 = $time;
            check($sformatf("R5 source code %0d period", src_code[s]), t1 - t0, 4 * src_half[s]);
            park();
        end

        // R4: bypass on the system clock
        src_sel = 3'b010;
        wait_cyc(4);
        ctrl_word = 6'b100000;
        wait_cyc(10);
        @(posedge clk_out); t0 = $time;
        @(posedge clk_out); t1 = $time;
        check("R4 bypass period", t1 - t0, 6);
        @(negedge clk_out); t2 = $time;
        check("R4 bypass high time", t2 - t1, 3);
        park();
        src_sel = 3'b000;
        wait_cyc(4);

        // R6: reserved source code
        src_sel = 3'b111;
        wait_cyc(2);
        ctrl_word = 6'b010000;
        e0 = edges;
        wait_cyc(60);
        check("R6 reserved code no edges", edges - e0, 0);
        ctrl_word = '0;
        wait_cyc(2);
        src_sel = 3'b000;
        wait_cyc(10);

        // R7: gate closed
        gate_en = 1'b0;
        wait_cyc(2);
        ctrl_word = 6'b010000;
        e0 = edges;
        wait_cyc(60);
        check("R7 gate closed no edges", edges - e0, 0);
        ctrl_word = '0;
        wait_cyc(2);
        gate_en = 1'b1;
        wait_cyc(10);

        // R8: reset taken mid-run
        ctrl_word = 6'b010010;
        wait_cyc(20);
        rst_n = 1'b0;
        ctrl_word = '0;
        #1;
        check("R8 reset forces out low", clk_out, 0);
        wait_cyc(3);
        rst_n = 1'b1;
        e0 = edges;
        wait_cyc(40);
        check("R8 enable treated as 0 after reset", edges - e0, 0);

        finish_run();
    end

endmodule